// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Signed-Overflow Flag

`int_alu` is the integer execution unit of a small RISC core. It takes two operands of `W` bits, a shift distance and a 4-bit operation code. It returns one result word and one flag, `ovf`, which is raised when a checked add or subtract produces a two's-complement value that does not fit in `W` bits.

The operation set has these groups:
- add and subtract, each in a checked form and an unchecked form;
- less-than compares, signed and unsigned, which return a 0/1 word;
- bitwise AND and OR;
- left shifts and two kinds of right shift, one filling with zeros and one filling with the sign.

The compare operations reuse the subtractor. The three shifts share one logarithmic shifter.

When `REG_OUT` is 1 (the default), the result and flag are captured in an output register. This register loads on `en` and clears on an asynchronous active-low reset. Results then appear one clock after the operands are presented. When `REG_OUT` is 0, the path is purely combinational.

Top module: `int_alu`

## Requirements
- R1: Code 0 (checked add) returns `(a + b) mod 2^W` and raises `ovf` exactly when both operands have the same sign and the sum has the other sign.
- R2: Code 1 (checked subtract) returns `(a - b) mod 2^W` and raises `ovf` exactly when the operand signs differ and the difference sign differs from that of `a`.
- R3: Code 2 (unchecked add) and code 3 (unchecked subtract) return the same words as codes 0 and 1, and `ovf` is always 0 for them.
- R4: Code 6 (signed less-than) returns 1 when `a < b` as two's-complement values and 0 otherwise; bits W-1:1 are always 0.
- R5: Code 7 (unsigned less-than) compares the operands as unsigned values, so `a=0xFFFFFFFA`, `b=0x0000FFFA` gives 0 here but 1 under code 6.
- R6: Code 4 returns `a & b` and code 5 returns `a | b`, bit by bit (for example, `0x12345678 | 0x0000FFFF = 0x1234FFFF`).
- R7: Code 8 shifts `a` left and code 9 shifts `a` right, both by `shamt` (0 to W-1), filling vacated bits with zeros.
- R8: Code 10 shifts `a` right by `shamt`, filling vacated bits with copies of bit W-1 (for example, `0x92345678` by 8 gives `0xFF923456`).
- R9: Codes 11 to 15 return 0, and `ovf` is 0 for every code other than 0 and 1.
- R10: With the output register enabled, reset (`rst_n` low) forces `result` and `ovf` to 0. Operands presented with `en` high appear one rising edge later. With `en` low, both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| en | input | 1 | Load enable of the output register |
| op_sel | input | 4 | Operation code (see requirements) |
| opnd_a | input | W | First operand; the value that is shifted |
| opnd_b | input | W | Second operand |
| shamt | input | clog2(W) | Shift distance |
| result | output | W | Result word |
| ovf | output | 1 | Signed-overflow flag for the checked add and subtract |

## Verification
The flag and the wrapped result are produced in the same cycle by the same adder. Checked operations that overflow must therefore deliver both the truncated word and `ovf = 1` together. The unchecked codes apply the same operands to confirm that the word is identical and the flag stays low. The stimulus uses sign-boundary operands (`0x7FFFFFFF + 1`, `0x80000000 + 0x80000000`, `0x80000000 - 1`), and each output pair is compared against both the fixed table and a bench model built with widened signed arithmetic. The same sharing is judged a second way: signed compares whose internal difference overflows (`0x7FFFFFFF < 0x80000000`) must still return the correct 0.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDU = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_SLT  = 4'd6,
    OP_SLTU = 4'd7,
    OP_SLL  = 4'd8,
    OP_SRL  = 4'd9,
    OP_SRA  = 4'd10
  } alu_op_e;
endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf_raw
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  assign b_eff = sub ? ~b : b;
  assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign sum   = full[W-1:0];
  assign carry = full[W];
  // signed overflow: same-sign inputs to the adder, result of the other sign
  assign ovf_raw = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   val,
  input  logic [SHW-1:0] amt,
  input  logic           left,
  input  logic           arith,
  output logic [W-1:0]   res
);
  logic [W-1:0] stg [0:SHW];
  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic         fill;

  assign fill = arith & ~left & val[W-1];

  // left shift = bit-reverse, right shift, bit-reverse
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = val[W-1-i];
    assign rev_out[i] = stg[SHW][W-1-i];
  end

  assign stg[0] = left ? rev_in : val;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stg[k+1] = amt[k] ? {{D{fill}}, stg[k][W-1:D]} : stg[k];
  end

  assign res = left ? rev_out : stg[SHW];
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int SHW    = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [3:0]     op_sel,
  input  logic [W-1:0]   opnd_a,
  input  logic [W-1:0]   opnd_b,
  input  logic [SHW-1:0] shamt,
  output logic [W-1:0]   result,
  output logic           ovf
);
  alu_op_e      op;
  logic         use_sub;
  logic [W-1:0] sum;
  logic         carry;
  logic         ovf_raw;
  logic [W-1:0] sh_res;
  logic         lt_s;
  logic         lt_u;
  logic [W-1:0] res_d;
  logic         ovf_d;

  assign op = alu_op_e'(op_sel);

  assign use_sub = (op == OP_SUB) || (op == OP_SUBU) ||
                   (op == OP_SLT) || (op == OP_SLTU);

  int_alu_addsub #(.W(W)) u_addsub (
    .a       (opnd_a),
    .b       (opnd_b),
    .sub     (use_sub),
    .sum     (sum),
    .carry   (carry),
    .ovf_raw (ovf_raw)
  );

  int_alu_shift #(.W(W), .SHW(SHW)) u_shift (
    .val   (opnd_a),
    .amt   (shamt),
    .left  (op == OP_SLL),
    .arith (op == OP_SRA),
    .res   (sh_res)
  );

  // compares taken from the shared subtractor
  assign lt_s = sum[W-1] ^ ovf_raw;
  assign lt_u = ~carry;

  // next-state
  always_comb begin
    res_d = '0;
    ovf_d = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        res_d = sum;
        ovf_d = ovf_raw;
      end
      OP_ADDU, OP_SUBU: res_d = sum;
      OP_AND:           res_d = opnd_a & opnd_b;
      OP_OR:            res_d = opnd_a | opnd_b;
      OP_SLT:           res_d = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:          res_d = {{(W-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA: res_d = sh_res;
      default: begin
        res_d = '0;
        ovf_d = 1'b0;
      end
    endcase
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        result <= '0;
        ovf    <= 1'b0;
      end else if (en) begin
        result <= res_d;
        ovf    <= ovf_d;
      end
    end
  end else begin : g_comb
    assign result = res_d;
    assign ovf    = ovf_d;
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1,
  parameter int SHW     = $clog2(W)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic [3:0]     op_sel,
  input logic [W-1:0]   opnd_a,
  input logic [SHW-1:0] shamt,
  input logic [W-1:0]   result,
  input logic           ovf
);
  if (REG_OUT) begin : g_chk
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(en) && ($past(op_sel) > 4'd1)) |-> !ovf);

    // R4
    cmp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(en) && (($past(op_sel) == 4'd6) || ($past(op_sel) == 4'd7)))
        |-> (result[W-1:1] == '0));

    // R8
    sra_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(en) && ($past(op_sel) == 4'd10))
        |-> (result[W-1] == $past(opnd_a[W-1])));

    // R9
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(en) && ($past(op_sel) >= 4'd11))
        |-> (result == '0));

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(en)) |-> ($stable(result) && $stable(ovf)));

    // R7
    sll_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(en) && ($past(op_sel) == 4'd8) && ($past(shamt) != '0))
        |-> (result[0] == 1'b0));
  end
endmodule

bind int_alu int_alu_chk #(.W(W), .REG_OUT(REG_OUT)) u_int_alu_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en),
  .op_sel (op_sel),
  .opnd_a (opnd_a),
  .shamt  (shamt),
  .result (result),
  .ovf    (ovf)
);

// File: tb/int_alu_bench.sv
module int_alu_bench;
  localparam int W   = 32;
  localparam int SHW = 5;
  localparam int NV  = 22;

  // entry: {req[3:0], op[3:0], a[31:0], b[31:0], sh[4:0], exp[31:0], ovf}
  localparam logic [109:0] VEC [0:NV-1] = '{
    {4'd1,  4'd0,  32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b1}, // R1
    {4'd1,  4'd0,  32'h00000005, 32'h00000003, 5'd0,  32'h00000008, 1'b0}, // R1
    {4'd1,  4'd0,  32'h80000000, 32'h80000000, 5'd0,  32'h00000000, 1'b1}, // R1
    {4'd2,  4'd1,  32'h80000000, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b1}, // R2
    {4'd2,  4'd1,  32'h00000005, 32'h00000007, 5'd0,  32'hFFFFFFFE, 1'b0}, // R2
    {4'd3,  4'd2,  32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b0}, // R3
    {4'd3,  4'd3,  32'h80000000, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b0}, // R3
    {4'd4,  4'd6,  32'hFFFFFFFA, 32'h0000FFFA, 5'd0,  32'h00000001, 1'b0}, // R4
    {4'd5,  4'd7,  32'hFFFFFFFA, 32'h0000FFFA, 5'd0,  32'h00000000, 1'b0}, // R5
    {4'd4,  4'd6,  32'h7FFFFFFF, 32'h80000000, 5'd0,  32'h00000000, 1'b0}, // R4
    {4'd5,  4'd7,  32'h00000001, 32'hFFFFFFFF, 5'd0,  32'h00000001, 1'b0}, // R5
    {4'd6,  4'd4,  32'hB6A43D9A, 32'h00000FFF, 5'd0,  32'h00000D9A, 1'b0}, // R6
    {4'd6,  4'd5,  32'h12345678, 32'h0000FFFF, 5'd0,  32'h1234FFFF, 1'b0}, // R6
    {4'd7,  4'd8,  32'h12345678, 32'h00000000, 5'd8,  32'h34567800, 1'b0}, // R7
    {4'd7,  4'd9,  32'h12345678, 32'h00000000, 5'd8,  32'h00123456, 1'b0}, // R7
    {4'd8,  4'd10, 32'h92345678, 32'h00000000, 5'd8,  32'hFF923456, 1'b0}, // R8
    {4'd8,  4'd10, 32'h12345678, 32'h00000000, 5'd8,  32'h00123456, 1'b0}, // R8
    {4'd7,  4'd9,  32'h80000000, 32'h00000000, 5'd31, 32'h00000001, 1'b0}, // R7
    {4'd8,  4'd10, 32'h80000000, 32'h00000000, 5'd31, 32'hFFFFFFFF, 1'b0}, // R8
    {4'd7,  4'd8,  32'h00000001, 32'h00000000, 5'd0,  32'h00000001, 1'b0}, // R7
    {4'd9,  4'd12, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3,  32'h00000000, 1'b0}, // R9
    {4'd9,  4'd15, 32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h00000000, 1'b0}  // R9
  };

  logic           clk;
  logic           rst_n;
  logic           en;
  logic [3:0]     op_sel;
  logic [W-1:0]   opnd_a;
  logic [W-1:0]   opnd_b;
  logic [SHW-1:0] shamt;
  logic [W-1:0]   result;
  logic           ovf;

  int checks;
  int fails;
  bit done;

  int_alu u_int_alu (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .op_sel (op_sel),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .shamt  (shamt),
    .result (result),
    .ovf    (ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // bench model built from the requirement text
  function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] s);
    longint sa, sb, wide;
    logic [31:0] r;
    logic        o;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    r = '0;
    o = 1'b0;
    case (op)
      4'd0, 4'd2: begin
        wide = sa + sb;
        r = a + b;
        o = (op == 4'd0) && ((wide > 64'sd2147483647) || (wide < -64'sd2147483648));
      end
      4'd1, 4'd3: begin
        wide = sa - sb;
        r = a - b;
        o = (op == 4'd1) && ((wide > 64'sd2147483647) || (wide < -64'sd2147483648));
      end
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = (sa < sb) ? 32'd1 : 32'd0;
      4'd7: r = (a < b) ? 32'd1 : 32'd0;
      4'd8: r = a << s;
      4'd9: r = a >> s;
      4'd10: r = $unsigned($signed(a) >>> s);
      default: r = '0;
    endcase
    return {o, r};
  endfunction

  task automatic check(input string req, input logic [31:0] exp_r, input logic exp_o);
    checks++;
    if (result !== exp_r || ovf !== exp_o) begin
      fails++;
      $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
               req, result, ovf, exp_r, exp_o);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] s);
    @(negedge clk);
    op_sel = op;
    opnd_a = a;
    opnd_b = b;
    shamt  = s;
    en     = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(2.5 * 2 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [32:0] m;
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    en     = 1'b0;
    op_sel = 4'd0;
    opnd_a = 32'h7FFFFFFF;
    opnd_b = 32'h00000001;
    shamt  = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset", 32'h0, 1'b0);
    rst_n = 1'b1;

    // fixed table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][105:102], VEC[i][101:70], VEC[i][69:38], VEC[i][37:33]);
      check($sformatf("R%0d vector %0d", VEC[i][109:106], i), VEC[i][32:1], VEC[i][0]);
    end

    // R1 R2 R3: simultaneous wrap and flag, against the model
    apply(4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0);
    check("R1 min plus minus-one", 32'h7FFFFFFF, 1'b1);
    apply(4'd2, 32'h80000000, 32'hFFFFFFFF, 5'd0);
    check("R3 unchecked add same operands", 32'h7FFFFFFF, 1'b0);
    apply(4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0);
    check("R2 max minus minus-one", 32'h80000000, 1'b1);

    // random sweep through the model, all codes
    for (int i = 0; i < 400; i++) begin
      logic [3:0]  op;
      logic [31:0] a, b;
      logic [4:0]  s;
      op = 4'($urandom_range(0, 15));
      a  = $urandom();
      b  = (i % 4 == 0) ? {~a[31], a[30:0]} : $urandom();
      s  = 5'($urandom_range(0, 31));
      apply(op, a, b, s);
      m = model(op, a, b, s);
      check($sformatf("R%0d random op %0d", (op <= 4'd1) ? op + 1 :
                      (op <= 4'd3) ? 3 : (op <= 4'd5) ? 6 : (op == 4'd6) ? 4 :
                      (op == 4'd7) ? 5 : (op <= 4'd9) ? 7 : (op == 4'd10) ? 8 : 9, op),
            m[31:0], m[32]);
    end

    // R10: hold with enable low
    apply(4'd0, 32'h7FFFFFFF, 32'h00000001, 5'd0);
    check("R10 load before hold", 32'h80000000, 1'b1);
    @(negedge clk);
    en     = 1'b0;
    op_sel = 4'd5;
    opnd_a = 32'h0000000F;
    opnd_b = 32'h000000F0;
    @(negedge clk);
    @(negedge clk);
    check("R10 hold while disabled", 32'h80000000, 1'b1);
    en = 1'b1;
    @(negedge clk);
    check("R10 load after enable", 32'h000000FF, 1'b0);

    // R10: asynchronous reset mid-run
    #1;
    rst_n = 1'b0;
    #1;
    check("R10 async clear", 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    finish_run();
  end
endmodule